// File: doc/BRIEF.md
# Serial ADC Port Device Model

A synthesizable model of the digital side of an 18-bit successive-approximation converter's serial port. It is meant to stand in for the converter in a testbench or on an emulation platform. The analogue part is replaced by a parallel sample input, and the conversion by a counter of system clock cycles. The convert, data-in and serial-clock lines are synchronised into the system clock. Their edges are found by comparing registered samples.

The levels of data-in and the serial clock at the convert rising edge choose the operating style. In select style a single device is read by pulling a select low, with or without a busy bit. In chain style devices are daisy-chained: each device's data-in feeds its own shift register, and an optional busy bit ripples down the chain. The data-out pin is given as a separate output-enable and value, so the integrator builds the tri-state buffer.

Top module: `adc_serial_port_model`

## Requirements
- R1: After reset, with convert and data-in held high, data-out is released (`sdo_oe_o` = 0).
- R2: At each convert rising edge that starts a conversion, the mode is latched: data-in high selects select style; data-in low with serial clock low selects chain style without busy; data-in low with serial clock high selects chain style with busy.
- R3: A conversion lasts `CONV_CYCLES` system clocks. Data-out is released throughout, whatever convert does, and a further convert rising edge during a conversion neither restarts nor shortens it.
- R4: The value returned is the one on `sample_i` at the end of the conversion, not at its start.
- R5: Outside a conversion and outside a readout, data-out is driven to 0 when convert and data-in are both low, and is released otherwise.
- R6: Chain style without busy: at the end of conversion data-out drives sample bit 17. Each serial-clock falling edge shifts left, taking data-in into bit 0, so data-out gives bits 17 down to 0 and then the data-in bits in the order they were taken.
- R7: Chain style with busy: after conversion data-out drives 0 until data-in is seen high, then drives 1, which stays until the next falling edge. The first falling edge ends the busy bit without taking data-in and shows bit 17. Later edges shift as in R6.
- R8: Select style, where the select is active when convert or data-in is low: if the select is inactive at the end of conversion, data-out stays released. When the select becomes active it drives bit 17, and it steps one bit per falling edge. It releases on the 18th falling edge.
- R9: Select style with the select active at the end of conversion: data-out drives a 0 busy bit. The first falling edge shows bit 17, and data-out releases on the 19th falling edge.
- R10: In select style, deactivating the select during a readout releases data-out at once, before the falling-edge count is reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_i | input | 1 | Convert line, asynchronous |
| sdi_i | input | 1 | Serial data-in / select line, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| sample_i | input | DATA_W | Conversion result presented in parallel |
| sdo_oe_o | output | 1 | Data-out driven when 1, high impedance when 0 |
| sdo_val_o | output | 1 | Data-out level when driven |

## Verification
The bench builds the model with an 18-bit sample, a 24-cycle conversion and two synchroniser stages. With a conversion this short, a second convert edge can land in mid-conversion and be told apart from a restart within a few cycles. The 18/19-edge release counts and the bits shifted in after the sample are also reached many times in a short run. Random samples and random data-in streams drive the chain styles, and directed runs cover the select style (with the select on convert and on data-in), early release and the idle drive-low rule.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  typedef enum logic [1:0] {
    MODE_CS         = 2'd0,
    MODE_CHAIN      = 2'd1,
    MODE_CHAIN_BUSY = 2'd2
  } port_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_HOLD = 2'd2,
    PH_OUT  = 2'd3
  } phase_e;
endpackage

// File: rtl/adc_port_sync.sv
module adc_port_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[i] <= RST_VAL;
        else        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/adc_port_timer.sv
module adc_port_timer #(
  parameter int CONV_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int TW = $clog2(CONV_CYCLES + 1);
  localparam logic [TW-1:0] LOAD_VAL = TW'(CONV_CYCLES - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end else if (start_i) begin
      run_d = 1'b1;
      cnt_d = LOAD_VAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign busy_o = run_q;
  assign done_o = run_q && (cnt_q == '0);

  AST_TIMER_START: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !run_q) |=> run_q); // R3
  AST_TIMER_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n) (run_q && cnt_q != '0) |=> run_q); // R3
endmodule

// File: rtl/adc_port_shifter.sv
module adc_port_shifter #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              lead_en_i,
  input  logic              lead_set_i,
  input  logic              shift_i,
  input  logic              sdi_i,
  output logic              bit_o
);
  logic [DATA_W-1:0] sr_q, sr_d;
  logic              lead_on_q, lead_on_d;
  logic              lead_val_q, lead_val_d;

  always_comb begin
    sr_d       = sr_q;
    lead_on_d  = lead_on_q;
    lead_val_d = lead_val_q;
    if (load_i) begin
      sr_d       = load_data_i;
      lead_on_d  = lead_en_i;
      lead_val_d = 1'b0;
    end else if (shift_i) begin
      if (lead_on_q) lead_on_d = 1'b0;
      else           sr_d      = {sr_q[DATA_W-2:0], sdi_i};
    end else if (lead_set_i && lead_on_q && sdi_i) begin
      lead_val_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q       <= '0;
      lead_on_q  <= 1'b0;
      lead_val_q <= 1'b0;
    end else begin
      sr_q       <= sr_d;
      lead_on_q  <= lead_on_d;
      lead_val_q <= lead_val_d;
    end
  end

  assign bit_o = lead_on_q ? lead_val_q : sr_q[DATA_W-1];

  AST_LEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (lead_on_q && lead_val_q && !load_i) |=> (!lead_on_q || lead_val_q)); // R7
  AST_LEAD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n) (lead_on_q && shift_i && !load_i) |=> (sr_q == $past(sr_q))); // R7
endmodule

// File: rtl/adc_serial_port_model.sv
module adc_serial_port_model
  import adc_port_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_i,
  input  logic              sdi_i,
  input  logic              sck_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_oe_o,
  output logic              sdo_val_o
);
  localparam int CNTW = $clog2(DATA_W + 2);
  localparam logic [CNTW-1:0] LAST_PLAIN = CNTW'(DATA_W - 1);
  localparam logic [CNTW-1:0] LAST_BUSY  = CNTW'(DATA_W);

  // synchronised pins: {convert, data-in, serial clock}
  logic [2:0] pins_s;
  logic       cnv_s, sdi_s, sck_s;
  logic       cnv_prev_q, sck_prev_q;
  logic       cnv_rise, sck_fall, sel;

  adc_port_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({cnv_i, sdi_i, sck_i}), .q_o(pins_s)
  );

  assign cnv_s = pins_s[2];
  assign sdi_s = pins_s[1];
  assign sck_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_prev_q <= 1'b1;
      sck_prev_q <= 1'b0;
    end else begin
      cnv_prev_q <= cnv_s;
      sck_prev_q <= sck_s;
    end
  end

  assign cnv_rise = cnv_s & ~cnv_prev_q;
  assign sck_fall = ~sck_s & sck_prev_q;
  assign sel      = ~(cnv_s & sdi_s);

  phase_e          phase_q, phase_d;
  port_mode_e      mode_q, mode_d;
  logic            cs_busy_q, cs_busy_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            start, tmr_busy, tmr_done;
  logic            load, lead_en, shift, lead_set, out_bit;
  logic [CNTW-1:0] last_edge;

  assign start     = cnv_rise && (phase_q != PH_CONV);
  assign last_edge = cs_busy_q ? LAST_BUSY : LAST_PLAIN;
  assign lead_set  = (phase_q == PH_OUT) && (mode_q == MODE_CHAIN_BUSY);

  adc_port_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(tmr_busy), .done_o(tmr_done)
  );

  adc_port_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_data_i(sample_i),
    .lead_en_i(lead_en), .lead_set_i(lead_set), .shift_i(shift),
    .sdi_i(sdi_s), .bit_o(out_bit)
  );

  always_comb begin
    phase_d   = phase_q;
    mode_d    = mode_q;
    cs_busy_d = cs_busy_q;
    cnt_d     = cnt_q;
    load      = 1'b0;
    lead_en   = 1'b0;
    shift     = 1'b0;
    if (phase_q == PH_CONV) begin
      if (tmr_done) begin
        load = 1'b1;
        if (mode_q == MODE_CS) begin
          cnt_d = '0;
          if (sel) begin
            lead_en   = 1'b1;
            cs_busy_d = 1'b1;
            phase_d   = PH_OUT;
          end else begin
            cs_busy_d = 1'b0;
            phase_d   = PH_HOLD;
          end
        end else begin
          lead_en = (mode_q == MODE_CHAIN_BUSY);
          phase_d = PH_OUT;
        end
      end
    end else if (cnv_rise) begin
      phase_d = PH_CONV;
      mode_d  = sdi_s ? MODE_CS : (sck_s ? MODE_CHAIN_BUSY : MODE_CHAIN);
    end else begin
      case (phase_q)
        PH_HOLD: if (sel) phase_d = PH_OUT;
        PH_OUT: begin
          if (mode_q == MODE_CS) begin
            if (!sel) begin
              phase_d = PH_IDLE;
            end else if (sck_fall) begin
              shift = 1'b1;
              cnt_d = cnt_q + 1'b1;
              if (cnt_q == last_edge) phase_d = PH_IDLE;
            end
          end else begin
            shift = sck_fall;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      mode_q    <= MODE_CS;
      cs_busy_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      phase_q   <= phase_d;
      mode_q    <= mode_d;
      cs_busy_q <= cs_busy_d;
      cnt_q     <= cnt_d;
    end
  end

  always_comb begin
    sdo_oe_o  = 1'b0;
    sdo_val_o = 1'b0;
    if (phase_q == PH_OUT) begin
      sdo_oe_o  = 1'b1;
      sdo_val_o = out_bit;
    end else if (phase_q != PH_CONV) begin
      sdo_oe_o  = ~cnv_s & ~sdi_s;
    end
  end

  AST_CONV_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_CONV) |-> !sdo_oe_o); // R3
  AST_CONV_TIMED: assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_CONV) |-> tmr_busy); // R3
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n) !start |=> $stable(mode_q)); // R2
  AST_HOLD_IS_CS: assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_HOLD) |-> (mode_q == MODE_CS)); // R8
  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_OUT && mode_q == MODE_CS && sel && sck_fall && !cnv_rise && cnt_q == last_edge) |=> (phase_q != PH_OUT)); // R9
  AST_CS_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_OUT && mode_q == MODE_CS && !sel) |=> (phase_q != PH_OUT)); // R10
endmodule

// File: tb/adc_serial_port_model_tb.sv
module adc_serial_port_model_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 18;
  localparam int CONV       = 24;
  localparam int SETTLE     = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cnv, sdi, sck;
  logic [DW-1:0] sample;
  logic          sdo_oe, sdo_val;
  int            n_run  = 0;
  int            n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_port_model #(.DATA_W(DW), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sdi_i(sdi), .sck_i(sck),
    .sample_i(sample), .sdo_oe_o(sdo_oe), .sdo_val_o(sdo_val)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp_oe, input logic exp_val);
    n_run++;
    if (sdo_oe !== exp_oe || (exp_oe && sdo_val !== exp_val)) begin
      n_fail++;
      $display("FAIL %s: oe=%0b val=%0b expected oe=%0b val=%0b", req, sdo_oe, sdo_val, exp_oe, exp_val);
    end
  endtask

  task automatic fall(input logic din);
    sdi = din;
    sck = 1'b1;
    step(4);
    sck = 1'b0;
    step(SETTLE);
  endtask

  // expected stream: sample MSB first, then taken data-in bits
  function automatic logic exp_stream(input logic [DW-1:0] s, input logic [63:0] ins, input int j);
    if (j < DW) return s[DW-1-j];
    return ins[j-DW];
  endfunction

  task automatic run_chain(input logic busy);
    logic [DW-1:0] s;
    logic [63:0]   ins;
    logic          d;
    ins = '0;
    cnv = 1'b0; sdi = 1'b0; sck = busy;
    step(SETTLE);
    cnv = 1'b1;
    step(SETTLE);
    check("R3 released during conversion", 1'b0, 1'b0);
    if (busy) sck = 1'b0;
    s = DW'($urandom);
    sample = s;
    step(CONV + 4);
    if (!busy) begin
      check("R6 MSB after conversion (R4 late sample)", 1'b1, s[DW-1]);
      for (int j = 1; j <= DW + 4; j++) begin
        d = 1'($urandom);
        ins[j-1] = d;
        fall(d);
        check("R6 chain shift", 1'b1, exp_stream(s, ins, j));
      end
    end else begin
      check("R7 busy bit low before data-in", 1'b1, 1'b0);
      sdi = 1'b1; step(SETTLE);
      check("R7 busy bit high", 1'b1, 1'b1);
      sdi = 1'b0; step(SETTLE);
      check("R7 busy bit sticky", 1'b1, 1'b1);
      fall(1'($urandom));
      check("R7 first edge shows MSB", 1'b1, s[DW-1]);
      for (int j = 2; j <= DW + 4; j++) begin
        d = 1'($urandom);
        ins[j-2] = d;
        fall(d);
        check("R7 chain shift after busy", 1'b1, exp_stream(s, ins, j-1));
      end
    end
  endtask

  initial begin
    logic [DW-1:0] s;
    void'($urandom(32'd1234));
    rst_n = 1'b0; cnv = 1'b1; sdi = 1'b1; sck = 1'b0; sample = '0;
    step(3);
    rst_n = 1'b1;
    step(SETTLE);
    check("R1 released after reset", 1'b0, 1'b0);

    cnv = 1'b0; sdi = 1'b0; step(SETTLE);
    check("R5 idle drive low", 1'b1, 1'b0);
    sdi = 1'b1; step(SETTLE);
    check("R5 idle released", 1'b0, 1'b0);

    // R2 chain without busy, random runs
    for (int k = 0; k < 4; k++) run_chain(1'b0);
    // R2 chain with busy
    for (int k = 0; k < 2; k++) run_chain(1'b1);

    // R8 select style, 3-wire, no busy
    cnv = 1'b0; sdi = 1'b1; sck = 1'b0; step(SETTLE);
    s = DW'($urandom); sample = s;
    cnv = 1'b1; step(SETTLE + CONV + 4);
    check("R8 held released while deselected", 1'b0, 1'b0);
    cnv = 1'b0; step(SETTLE);
    check("R8 MSB on select", 1'b1, s[DW-1]);
    for (int j = 1; j < DW; j++) begin
      fall(1'b1);
      check("R8 select shift", 1'b1, s[DW-1-j]);
    end
    fall(1'b1);
    check("R8 release on 18th edge", 1'b0, 1'b0);

    // R10 select style, 4-wire, early release
    cnv = 1'b0; sdi = 1'b1; step(SETTLE);
    s = DW'($urandom); sample = s;
    cnv = 1'b1; step(SETTLE + CONV + 4);
    check("R8 4-wire held released", 1'b0, 1'b0);
    sdi = 1'b0; step(SETTLE);
    check("R8 4-wire MSB on select", 1'b1, s[DW-1]);
    for (int j = 1; j <= 5; j++) fall(1'b0);
    check("R8 4-wire shift", 1'b1, s[DW-6]);
    sdi = 1'b1; step(SETTLE);
    check("R10 release on deselect", 1'b0, 1'b0);

    // R9 select style with busy bit, 3-wire
    cnv = 1'b0; sdi = 1'b1; step(SETTLE);
    s = DW'($urandom); sample = s;
    cnv = 1'b1; step(SETTLE);
    cnv = 1'b0; step(4);
    check("R3 released despite convert low", 1'b0, 1'b0);
    step(CONV);
    check("R9 busy bit low", 1'b1, 1'b0);
    for (int j = 1; j <= DW; j++) begin
      fall(1'b1);
      check("R9 busy readout", 1'b1, s[DW-j]);
    end
    fall(1'b1);
    check("R9 release on 19th edge", 1'b0, 1'b0);

    // R3 second convert edge mid-conversion does not restart
    cnv = 1'b0; sdi = 1'b0; sck = 1'b0; step(SETTLE);
    s = DW'($urandom); sample = s;
    cnv = 1'b1; step(12);
    cnv = 1'b0; step(4);
    cnv = 1'b1; step(CONV - 8);
    check("R3 no restart on second edge", 1'b1, s[DW-1]);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule